// File: doc/BRIEF.md
# SIMD Set Co-Issue Packer

After a scheduler has issued one warp instruction to a functional unit, that instruction may occupy only some of the unit's SIMD lane groups ("sets"). This block fills the idle sets with instructions from other warps in the same scheduler cycle. It takes the primary instruction's per-set occupancy and a priority-ordered list of candidate warps. A candidate is packed in when it is ready, has no control or register hazard, targets the same unit class, and needs only sets that are still free.

Candidates are evaluated in a chain from index 0, which has the highest priority. Each grant updates the composite occupancy before the next candidate is evaluated, so a lower-priority candidate sees the sets taken by every grant above it. The block registers three results: the merged set vector, a per-set owner warp id, and a per-candidate grant pulse. The grant pulse steps that warp's instruction buffer. All three results become valid one clock after the inputs are presented.

Top module: `simd_copack`

## Requirements
- R1: While reset is asserted, and on the first sample after reset, the composite set vector, the owner field of every set and every grant are zero.
- R2: Packing is attempted only when `part_en` is 1, `prim_issued` is 1, and `prim_fu` is neither 0 (no unit) nor 1 (memory). Otherwise no grant is given and the composite equals `prim_sets`. The unit class codes are 0 none, 1 memory, 2 SP, 3 INT, 4 DP, 5 SFU, 6 tensor and 7 specialized.
- R3: When `prim_issued` is 0, the next registered composite, owners and grants are all zero.
- R4: The number of free sets is the number of zero bits in `prim_sets`. When it is zero, no candidate is granted.
- R5: Candidate 0 has the highest priority. A candidate sees the sets taken by all earlier grants in the same cycle, and a candidate is only considered while at least one free set remains.
- R6: A candidate is skipped if any of these holds: it is not present, it has exited, its warp id equals `prim_warp`, its instruction buffer is empty, its next buffer entry is not valid, or it is waiting.
- R7: When `aware_mode` is 1, a candidate also needs valid=1, blocked=0, pending-reconvergence=0 and virtualized=0. When `aware_mode` is 0, these four flags have no effect.
- R8: A candidate is rejected if its PC differs from its reconvergence-stack top PC, or if its scoreboard-collision flag is 1.
- R9: A candidate is rejected if its unit class differs from `prim_fu`.
- R10: A candidate is rejected if any of its set bits is already set in the composite, or if its count of set bits exceeds the number of sets still free.
- R11: On a grant, the candidate's sets are ORed into the composite and the owner field of each such set becomes the candidate's warp id. Sets used by the primary instruction are owned by `prim_warp`. Unused sets have owner 0. The owner of set s is in `set_owner[s*WARP_W +: WARP_W]`.
- R12: `grant[i]` is a registered pulse that appears one clock after the candidate inputs and lasts one cycle per evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| part_en | input | 1 | Set partitioning enabled |
| prim_issued | input | 1 | A primary instruction issued this cycle |
| aware_mode | input | 1 | Reconvergence-aware eligibility mode |
| prim_fu | input | 3 | Unit class of the primary instruction |
| prim_warp | input | WARP_W | Primary warp id |
| prim_sets | input | NUM_SETS | Sets used by the primary instruction |
| cand_present | input | NUM_CAND | Candidate slot holds a warp |
| cand_exited | input | NUM_CAND | Candidate warp has exited |
| cand_ibuf_empty | input | NUM_CAND | Candidate instruction buffer empty |
| cand_next_valid | input | NUM_CAND | Candidate next buffer entry valid |
| cand_waiting | input | NUM_CAND | Candidate waiting |
| cand_valid | input | NUM_CAND | Candidate valid (aware mode) |
| cand_blocked | input | NUM_CAND | Candidate blocked (aware mode) |
| cand_pend_reconv | input | NUM_CAND | Candidate pending reconvergence (aware mode) |
| cand_virt | input | NUM_CAND | Candidate virtualized (aware mode) |
| cand_collide | input | NUM_CAND | Scoreboard collision |
| cand_warp | input | NUM_CAND*WARP_W | Candidate warp ids |
| cand_fu | input | NUM_CAND*3 | Candidate unit classes |
| cand_pc | input | NUM_CAND*PC_W | Candidate PCs |
| cand_tos_pc | input | NUM_CAND*PC_W | Candidate reconvergence-stack top PCs |
| cand_sets | input | NUM_CAND*NUM_SETS | Candidate per-set valid vectors |
| comp_sets | output | NUM_SETS | Registered merged set vector |
| set_owner | output | NUM_SETS*WARP_W | Registered owner warp id per set |
| grant | output | NUM_CAND | Registered co-issue grant pulses |

## Verification
A wrong free-set count or a stale composite inside the chain shows up one clock later. It appears as a grant given to an overlapping or oversized candidate, or as a grant withheld from a fitting one. In both cases `comp_sets` or `set_owner` disagrees in the same sample. A fault in eligibility decoding appears as a wrong `grant` bit in that same registered cycle. The sweep crosses every primary occupancy with every pattern for two candidates, while two further candidates depend on them, so ordering faults surface within a few thousand cycles.

// File: rtl/simd_copack_pkg.sv
package simd_copack_pkg;
  localparam int CLASS_W = 3;

  typedef enum logic [CLASS_W-1:0] {
    UC_NONE   = 3'd0,
    UC_MEM    = 3'd1,
    UC_SP     = 3'd2,
    UC_INT    = 3'd3,
    UC_DP     = 3'd4,
    UC_SFU    = 3'd5,
    UC_TENSOR = 3'd6,
    UC_SPEC   = 3'd7
  } unit_class_e;

  // population count of a set vector, zero-extended to 32 bits
  function automatic logic [6:0] ones32(logic [31:0] v);
    logic [6:0] n;
    n = '0;
    for (int k = 0; k < 32; k++) n = n + {6'd0, v[k]};
    return n;
  endfunction

  // packing applies only to partitioned non-memory classes
  function automatic logic class_packable(logic [CLASS_W-1:0] c);
    return (c != UC_NONE) && (c != UC_MEM);
  endfunction
endpackage

// File: rtl/simd_cand_elig.sv
module simd_cand_elig
  import simd_copack_pkg::*;
#(
  parameter int WARP_W = 5,
  parameter int PC_W   = 16
) (
  input  logic               aware_mode,
  input  logic [WARP_W-1:0]  prim_warp,
  input  logic [CLASS_W-1:0] prim_fu,
  input  logic               present,
  input  logic               exited,
  input  logic               ibuf_empty,
  input  logic               next_valid,
  input  logic               waiting,
  input  logic               valid,
  input  logic               blocked,
  input  logic               pend_reconv,
  input  logic               virt,
  input  logic               collide,
  input  logic [WARP_W-1:0]  warp,
  input  logic [CLASS_W-1:0] fu,
  input  logic [PC_W-1:0]    pc,
  input  logic [PC_W-1:0]    tos_pc,
  output logic               eligible
);
  logic basic_ok, aware_ok, hazard_ok, class_ok;

  assign basic_ok  = present && !exited && (warp != prim_warp) &&
                     !ibuf_empty && next_valid && !waiting;
  assign aware_ok  = !aware_mode || (valid && !blocked && !pend_reconv && !virt);
  assign hazard_ok = (pc == tos_pc) && !collide;
  assign class_ok  = (fu == prim_fu);
  assign eligible  = basic_ok && aware_ok && hazard_ok && class_ok;
endmodule

// File: rtl/simd_pack_chain.sv
module simd_pack_chain
  import simd_copack_pkg::*;
#(
  parameter int NUM_SETS = 4,
  parameter int NUM_CAND = 4,
  parameter int WARP_W   = 5
) (
  input  logic                         attempt,
  input  logic [NUM_SETS-1:0]          prim_sets,
  input  logic [WARP_W-1:0]            prim_warp,
  input  logic [NUM_CAND-1:0]          elig,
  input  logic [NUM_CAND*NUM_SETS-1:0] cand_sets,
  input  logic [NUM_CAND*WARP_W-1:0]   cand_warp,
  output logic [NUM_SETS-1:0]          comp_sets,
  output logic [NUM_SETS*WARP_W-1:0]   set_owner,
  output logic [NUM_CAND-1:0]          take
);
  localparam int CNT_W = $clog2(NUM_SETS + 1);
  localparam int OWN_W = NUM_SETS * WARP_W;

  logic [OWN_W-1:0] own_init;
  logic [CNT_W-1:0] free_init;

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_init
    assign own_init[s*WARP_W +: WARP_W] = prim_sets[s] ? prim_warp : '0;
  end
  assign free_init = CNT_W'(NUM_SETS) - CNT_W'(ones32(32'(prim_sets)));

  for (genvar i = 0; i < NUM_CAND; i++) begin : stg
    logic [NUM_SETS-1:0] cs, comp_in, comp_out;
    logic [CNT_W-1:0]    free_in, free_out, need;
    logic [OWN_W-1:0]    own_in, own_out;
    logic                room, clash, fits;

    if (i == 0) begin : g_first
      assign comp_in = prim_sets;
      assign free_in = free_init;
      assign own_in  = own_init;
    end else begin : g_next
      assign comp_in = stg[i-1].comp_out;
      assign free_in = stg[i-1].free_out;
      assign own_in  = stg[i-1].own_out;
    end

    assign cs    = cand_sets[i*NUM_SETS +: NUM_SETS];
    assign need  = CNT_W'(ones32(32'(cs)));
    assign room  = (free_in != '0);
    assign clash = |(comp_in & cs);
    assign fits  = (need <= free_in);
    assign take[i] = attempt && elig[i] && room && !clash && fits;

    assign comp_out = take[i] ? (comp_in | cs) : comp_in;
    assign free_out = take[i] ? (free_in - need) : free_in;

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_own
      assign own_out[s*WARP_W +: WARP_W] = (take[i] && cs[s]) ?
          cand_warp[i*WARP_W +: WARP_W] : own_in[s*WARP_W +: WARP_W];
    end
  end

  assign comp_sets = stg[NUM_CAND-1].comp_out;
  assign set_owner = stg[NUM_CAND-1].own_out;
endmodule

// File: rtl/simd_copack.sv
module simd_copack
  import simd_copack_pkg::*;
#(
  parameter int NUM_SETS = 4,
  parameter int NUM_CAND = 4,
  parameter int WARP_W   = 5,
  parameter int PC_W     = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         part_en,
  input  logic                         prim_issued,
  input  logic                         aware_mode,
  input  logic [2:0]                   prim_fu,
  input  logic [WARP_W-1:0]            prim_warp,
  input  logic [NUM_SETS-1:0]          prim_sets,
  input  logic [NUM_CAND-1:0]          cand_present,
  input  logic [NUM_CAND-1:0]          cand_exited,
  input  logic [NUM_CAND-1:0]          cand_ibuf_empty,
  input  logic [NUM_CAND-1:0]          cand_next_valid,
  input  logic [NUM_CAND-1:0]          cand_waiting,
  input  logic [NUM_CAND-1:0]          cand_valid,
  input  logic [NUM_CAND-1:0]          cand_blocked,
  input  logic [NUM_CAND-1:0]          cand_pend_reconv,
  input  logic [NUM_CAND-1:0]          cand_virt,
  input  logic [NUM_CAND-1:0]          cand_collide,
  input  logic [NUM_CAND*WARP_W-1:0]   cand_warp,
  input  logic [NUM_CAND*3-1:0]        cand_fu,
  input  logic [NUM_CAND*PC_W-1:0]     cand_pc,
  input  logic [NUM_CAND*PC_W-1:0]     cand_tos_pc,
  input  logic [NUM_CAND*NUM_SETS-1:0] cand_sets,
  output logic [NUM_SETS-1:0]          comp_sets,
  output logic [NUM_SETS*WARP_W-1:0]   set_owner,
  output logic [NUM_CAND-1:0]          grant
);
  localparam int OWN_W = NUM_SETS * WARP_W;

  // named internal events
  logic                attempt;
  logic [NUM_CAND-1:0] elig_vec;
  logic [NUM_CAND-1:0] take_vec;
  logic [NUM_SETS-1:0] merged_sets;
  logic [OWN_W-1:0]    merged_owner;

  assign attempt = part_en && prim_issued && class_packable(prim_fu);

  for (genvar i = 0; i < NUM_CAND; i++) begin : g_elig
    simd_cand_elig #(.WARP_W(WARP_W), .PC_W(PC_W)) u_elig (
      .aware_mode (aware_mode),
      .prim_warp  (prim_warp),
      .prim_fu    (prim_fu),
      .present    (cand_present[i]),
      .exited     (cand_exited[i]),
      .ibuf_empty (cand_ibuf_empty[i]),
      .next_valid (cand_next_valid[i]),
      .waiting    (cand_waiting[i]),
      .valid      (cand_valid[i]),
      .blocked    (cand_blocked[i]),
      .pend_reconv(cand_pend_reconv[i]),
      .virt       (cand_virt[i]),
      .collide    (cand_collide[i]),
      .warp       (cand_warp[i*WARP_W +: WARP_W]),
      .fu         (cand_fu[i*3 +: 3]),
      .pc         (cand_pc[i*PC_W +: PC_W]),
      .tos_pc     (cand_tos_pc[i*PC_W +: PC_W]),
      .eligible   (elig_vec[i])
    );
  end

  simd_pack_chain #(.NUM_SETS(NUM_SETS), .NUM_CAND(NUM_CAND), .WARP_W(WARP_W)) u_chain (
    .attempt  (attempt),
    .prim_sets(prim_sets),
    .prim_warp(prim_warp),
    .elig     (elig_vec),
    .cand_sets(cand_sets),
    .cand_warp(cand_warp),
    .comp_sets(merged_sets),
    .set_owner(merged_owner),
    .take     (take_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      comp_sets <= '0;
      set_owner <= '0;
      grant     <= '0;
    end else if (prim_issued) begin
      comp_sets <= merged_sets;
      set_owner <= merged_owner;
      grant     <= take_vec;
    end else begin
      comp_sets <= '0;
      set_owner <= '0;
      grant     <= '0;
    end
  end

  AST_NO_ATTEMPT_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !(part_en && prim_issued && prim_fu != 3'd0 && prim_fu != 3'd1) |=> grant == '0); // R2
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !prim_issued |=> (comp_sets == '0 && grant == '0)); // R3
  AST_FULL_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (prim_issued && &prim_sets) |=> grant == '0); // R4
  AST_PRIMARY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    prim_issued |=> ((comp_sets & $past(prim_sets)) == $past(prim_sets))); // R11

  for (genvar i = 0; i < NUM_CAND; i++) begin : g_chk
    AST_NOT_SELF: assert property (@(posedge clk) disable iff (!rst_n)
      grant[i] |-> $past(cand_warp[i*WARP_W +: WARP_W]) != $past(prim_warp)); // R6
    AST_GRANT_COVERED: assert property (@(posedge clk) disable iff (!rst_n)
      grant[i] |-> ((comp_sets & $past(cand_sets[i*NUM_SETS +: NUM_SETS])) ==
                    $past(cand_sets[i*NUM_SETS +: NUM_SETS]))); // R10
    AST_GRANT_NO_PRIM_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      grant[i] |-> ($past(cand_sets[i*NUM_SETS +: NUM_SETS]) & $past(prim_sets)) == '0); // R10
  end
endmodule

// File: tb/tb_simd_copack.sv
module tb_simd_copack;
  localparam int NS = 4, NC = 4, WW = 5, PW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic part_en, prim_issued, aware_mode;
  logic [2:0] prim_fu;
  logic [WW-1:0] prim_warp;
  logic [NS-1:0] prim_sets;
  logic [NC-1:0] c_present, c_exited, c_ibuf_empty, c_next_valid, c_waiting;
  logic [NC-1:0] c_valid, c_blocked, c_pend, c_virt, c_collide;
  logic [NC*WW-1:0] c_warp;
  logic [NC*3-1:0] c_fu;
  logic [NC*PW-1:0] c_pc, c_tos;
  logic [NC*NS-1:0] c_sets;
  logic [NS-1:0] comp_sets;
  logic [NS*WW-1:0] set_owner;
  logic [NC-1:0] grant;

  logic [NS-1:0] exp_comp;
  logic [NS*WW-1:0] exp_owner;
  logic [NC-1:0] exp_grant;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  simd_copack #(.NUM_SETS(NS), .NUM_CAND(NC), .WARP_W(WW), .PC_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .part_en(part_en), .prim_issued(prim_issued),
    .aware_mode(aware_mode), .prim_fu(prim_fu), .prim_warp(prim_warp),
    .prim_sets(prim_sets), .cand_present(c_present), .cand_exited(c_exited),
    .cand_ibuf_empty(c_ibuf_empty), .cand_next_valid(c_next_valid),
    .cand_waiting(c_waiting), .cand_valid(c_valid), .cand_blocked(c_blocked),
    .cand_pend_reconv(c_pend), .cand_virt(c_virt), .cand_collide(c_collide),
    .cand_warp(c_warp), .cand_fu(c_fu), .cand_pc(c_pc), .cand_tos_pc(c_tos),
    .cand_sets(c_sets), .comp_sets(comp_sets), .set_owner(set_owner), .grant(grant)
  );

  task automatic defaults();
    part_en = 1; prim_issued = 1; aware_mode = 0;
    prim_fu = 3'd2; prim_warp = 5'd0; prim_sets = 4'b0001;
    c_present = '1; c_exited = '0; c_ibuf_empty = '0; c_next_valid = '1;
    c_waiting = '0; c_valid = '1; c_blocked = '0; c_pend = '0; c_virt = '0;
    c_collide = '0; c_sets = '0;
    for (int i = 0; i < NC; i++) begin
      c_warp[i*WW +: WW] = WW'(i + 1);
      c_fu[i*3 +: 3] = 3'd2;
      c_pc[i*PW +: PW] = PW'(16'h0100 + i*4);
      c_tos[i*PW +: PW] = PW'(16'h0100 + i*4);
    end
  endtask

  // reference model built from the requirement list
  task automatic model();
    int avail, need;
    bit ok, over;
    logic [NS-1:0] cs;
    exp_grant = '0; exp_comp = '0; exp_owner = '0;
    if (!prim_issued) return;
    exp_comp = prim_sets;
    for (int s = 0; s < NS; s++) if (prim_sets[s]) exp_owner[s*WW +: WW] = prim_warp;
    if (!part_en || prim_fu == 3'd0 || prim_fu == 3'd1) return;
    avail = 0;
    for (int s = 0; s < NS; s++) if (!prim_sets[s]) avail++;
    for (int i = 0; i < NC; i++) begin
      if (avail == 0) break;
      ok = 1;
      if (!c_present[i] || c_exited[i] || c_ibuf_empty[i] || !c_next_valid[i] || c_waiting[i]) ok = 0;
      if (c_warp[i*WW +: WW] == prim_warp) ok = 0;
      if (aware_mode && (!c_valid[i] || c_blocked[i] || c_pend[i] || c_virt[i])) ok = 0;
      if (c_pc[i*PW +: PW] != c_tos[i*PW +: PW] || c_collide[i]) ok = 0;
      if (c_fu[i*3 +: 3] != prim_fu) ok = 0;
      cs = c_sets[i*NS +: NS];
      over = 0; need = 0;
      for (int s = 0; s < NS; s++) begin
        if (cs[s]) need++;
        if (cs[s] && exp_comp[s]) over = 1;
      end
      if (ok && !over && need <= avail) begin
        exp_grant[i] = 1'b1;
        for (int s = 0; s < NS; s++)
          if (cs[s]) begin
            exp_comp[s] = 1'b1;
            exp_owner[s*WW +: WW] = c_warp[i*WW +: WW];
          end
        avail -= need;
      end
    end
  endtask

  task automatic compare(string tag);
    tests++;
    if (comp_sets !== exp_comp || set_owner !== exp_owner || grant !== exp_grant) begin
      fails++;
      $display("FAIL %s: got comp=%b owner=%h grant=%b, expected comp=%b owner=%h grant=%b",
               tag, comp_sets, set_owner, grant, exp_comp, exp_owner, exp_grant);
    end
  endtask

  // inputs already driven at a negedge; result appears after the next posedge
  task automatic step(string tag);
    model();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    exp_comp = '0; exp_owner = '0; exp_grant = '0;
    compare("R1 in reset");
    rst_n = 1;
    prim_issued = 0;
    step("R1 after reset");

    // R11 basic merge with owners
    defaults();
    c_sets = {4'b1000, 4'b0100, 4'b0010, 4'b0000};
    c_sets[0 +: 4] = 4'b0010; c_sets[4 +: 4] = 4'b0100; c_sets[8 +: 4] = 4'b1000; c_sets[12 +: 4] = 4'b0000;
    step("R11 merge");
    // R12 pulse drops
    prim_issued = 0;
    step("R12 pulse clear");
    // R5 priority: same set wanted twice
    defaults();
    c_sets[0 +: 4] = 4'b0110; c_sets[4 +: 4] = 4'b0100; c_sets[8 +: 4] = 4'b1000; c_sets[12 +: 4] = 4'b1000;
    step("R5 priority");
    // R6 each skip condition on candidate 0
    for (int k = 0; k < 6; k++) begin
      defaults();
      c_sets[0 +: 4] = 4'b0010; c_sets[4 +: 4] = 4'b0010;
      case (k)
        0: c_present[0] = 0;
        1: c_exited[0] = 1;
        2: c_warp[0 +: WW] = 5'd0;
        3: c_ibuf_empty[0] = 1;
        4: c_next_valid[0] = 0;
        default: c_waiting[0] = 1;
      endcase
      step("R6 skip");
    end
    // R7 aware-mode flags, both modes
    for (int m = 0; m < 2; m++)
      for (int k = 0; k < 4; k++) begin
        defaults();
        aware_mode = m[0];
        c_sets[0 +: 4] = 4'b0110;
        case (k)
          0: c_valid[0] = 0;
          1: c_blocked[0] = 1;
          2: c_pend[0] = 1;
          default: c_virt[0] = 1;
        endcase
        step("R7 aware flags");
      end
    // R8 hazards
    defaults(); c_sets[0 +: 4] = 4'b0010; c_tos[0 +: PW] = 16'h0200; step("R8 pc mismatch");
    defaults(); c_sets[0 +: 4] = 4'b0010; c_collide[0] = 1; step("R8 collision");
    // R9 class mismatch and class sweep
    defaults(); c_sets[0 +: 4] = 4'b0010; c_fu[0 +: 3] = 3'd5; step("R9 class mismatch");
    for (int f = 0; f < 8; f++) begin
      defaults();
      prim_fu = 3'(f);
      for (int i = 0; i < NC; i++) c_fu[i*3 +: 3] = 3'(f);
      c_sets[0 +: 4] = 4'b0010; c_sets[4 +: 4] = 4'b1100;
      step("R2 class sweep");
    end
    // R2 disabled
    defaults(); part_en = 0; c_sets[0 +: 4] = 4'b0010; step("R2 partition off");
    // R3 nothing issued
    defaults(); prim_issued = 0; c_sets[0 +: 4] = 4'b0010; step("R3 no primary");
    // R4 full primary
    defaults(); prim_sets = 4'b1111; c_sets[0 +: 4] = 4'b0000; step("R4 full");
    // R10 overlap with primary
    defaults(); c_sets[0 +: 4] = 4'b0011; c_sets[4 +: 4] = 4'b1110; step("R10 overlap");

    // sweep: every primary occupancy against every pattern of two candidates
    for (int p = 0; p < 16; p++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          defaults();
          prim_sets = 4'(p);
          aware_mode = b[2];
          c_sets[0 +: 4] = 4'(a);
          c_sets[4 +: 4] = 4'(b);
          c_sets[8 +: 4] = ~4'(a);
          c_sets[12 +: 4] = 4'(1 << (p % 4));
          c_waiting[2] = a[0] & b[0];
          c_blocked[1] = a[3];
          if (b[1]) c_fu[12 +: 3] = 3'd3;
          if (p == a) c_warp[4 +: WW] = 5'd0;
          step("R10 R5 sweep");
        end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule